// File: doc/BRIEF.md
# Card-Side Write Block Receiver

This block sits on the card side of a single serial data line and takes in one fixed-size write block from the host. A strobe marks the end of the card's own command response. The block then lets a minimum turnaround gap pass and waits for the host's start bit. It shifts in 4096 payload bits, a 16-bit checksum and an end bit. Payload bytes go out to the programming side as they complete. The block then returns a framed three-bit verdict on the same line.

After the verdict, the card may hold the line low for as long as both of its receive buffers are taken. The line is released when the programming model frees a buffer. The line itself is modelled as an output enable and an output value. The host's pull-up is assumed, so the line reads high whenever nobody drives it.

Top module: `blk_write_rx`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears all state. dat_oe, rx_byte_valid, blk_good and blk_bad are 0, no buffer is held, and a reception in progress is abandoned.
- R2: A resp_done sampled high in the idle state starts a turnaround gap. The next GAP_MIN samples of dat_in are ignored, even when they are low. The start bit is the first low sample after the gap, and the line may stay high for any number of cycles before it.
- R3: The 512-byte payload arrives most significant bit first in each byte. rx_byte_valid pulses for one cycle after each eighth payload bit, with the completed byte on rx_byte, so each block gives exactly 512 pulses.
- R4: The 16 bits after the payload are a checksum with polynomial x^16+x^12+x^5+1 and initial value zero, sent most significant bit first, followed by an end bit that must be 1. On a match with a high end bit, blk_good pulses for one cycle after the end-bit edge, the status bits are 010, and one buffer becomes occupied.
- R5: On a checksum mismatch or a low end bit, blk_bad pulses instead, the status bits are 101, and buffer occupancy does not change.
- R6: Let the end bit be sampled at edge k. dat_oe stays low after edges k and k+1. After edges k+2 to k+6, dat_oe is high and dat_out carries 0, the three status bits in order, and then 1.
- R7: There are two buffers. If both are occupied after the token, dat_oe stays high with dat_out low from edge k+7 for as long as no release arrives. Otherwise dat_oe is low from k+7.
- R8: A buf_release sampled high frees one occupied buffer. A release during busy ends the busy at that edge. A release with no buffer occupied has no effect.
- R9: resp_done is ignored in every state except idle. This includes the middle of a reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; the line is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| resp_done | input | 1 | One-cycle strobe at the end of the card's command response |
| dat_in | input | 1 | Sampled level of the data line |
| buf_release | input | 1 | Programming model frees one receive buffer |
| dat_oe | output | 1 | Card drives the data line when high |
| dat_out | output | 1 | Level driven while dat_oe is high |
| rx_byte | output | 8 | Most recently completed payload byte |
| rx_byte_valid | output | 1 | One-cycle strobe: rx_byte holds a new byte |
| blk_good | output | 1 | One-cycle strobe: block passed its checks |
| blk_bad | output | 1 | One-cycle strobe: block failed and is discarded |

## Verification
A bit counter that is off by one shows up quickly. It misaligns the bytes on rx_byte within eight bits and moves the verdict one edge. That shift is visible in the first token sample two cycles after the end bit. A wrong checksum register turns 010 into 101 at that same token. Occupancy errors stay hidden until the next good block, when busy either appears with a free buffer or fails to appear with both buffers held. The bench therefore chains blocks and releases so that every occupancy level is seen at a token.

// File: rtl/blk_write_rx.sv
module blk_write_rx #(
  parameter int BLOCK_BYTES = 512,
  parameter int GAP_MIN     = 2,
  parameter int TURN_CYC    = 2,
  parameter int NUM_BUF     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       resp_done,
  input  logic       dat_in,
  input  logic       buf_release,
  output logic       dat_oe,
  output logic       dat_out,
  output logic [7:0] rx_byte,
  output logic       rx_byte_valid,
  output logic       blk_good,
  output logic       blk_bad
);
  localparam int NBITS  = BLOCK_BYTES * 8;
  localparam int CRC_W  = 16;
  localparam int TOK_W  = 5;
  localparam int CW_D   = $clog2(NBITS);
  localparam int CW_G   = $clog2(GAP_MIN + 1);
  localparam int CW_T   = $clog2(TURN_CYC + 1);
  localparam int CW_0   = (CW_D > CW_G) ? CW_D : CW_G;
  localparam int CW_1   = (CW_0 > CW_T) ? CW_0 : CW_T;
  localparam int CW     = ((CW_1 > 4) ? CW_1 : 4) + 1;
  localparam int OW     = $clog2(NUM_BUF + 1);
  localparam logic [OW-1:0] FULL = OW'(NUM_BUF);
  localparam logic [CW-1:0] LAST_DATA = CW'(NBITS - 1);
  localparam logic [CW-1:0] LAST_CRC  = CW'(CRC_W - 1);
  localparam logic [CW-1:0] LAST_GAP  = CW'(GAP_MIN - 1);
  localparam logic [CW-1:0] LAST_TURN = CW'(TURN_CYC - 1);
  localparam logic [CW-1:0] LAST_TOK  = CW'(TOK_W - 1);
  localparam logic [CRC_W-1:0] POLY   = 16'h1021;

  typedef enum logic [3:0] {
    S_IDLE, S_GAP, S_HUNT, S_DATA, S_CRC, S_ENDB, S_TURN, S_TOK, S_BUSY
  } st_t;

  st_t              state;
  logic [CW-1:0]    cnt;
  logic [CRC_W-1:0] crc;
  logic [7:0]       shreg;
  logic [TOK_W-1:0] tok;
  logic [OW-1:0]    occ, occ_nxt;

  wire [CRC_W-1:0] crc_step = {crc[CRC_W-2:0], 1'b0} ^ ({CRC_W{crc[CRC_W-1] ^ dat_in}} & POLY);
  wire pass = (crc == '0) && dat_in;
  wire add  = (state == S_ENDB) && pass;
  wire rel  = buf_release && (occ != '0);

  always_comb begin
    occ_nxt = occ;
    if (add && !rel)      occ_nxt = occ + 1'b1;
    else if (rel && !add) occ_nxt = occ - 1'b1;
  end

  assign dat_oe  = (state == S_TOK) || (state == S_BUSY);
  assign dat_out = (state == S_TOK) ? tok[TOK_W-1] : 1'b0;
  assign rx_byte = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      cnt           <= '0;
      crc           <= '0;
      shreg         <= '0;
      tok           <= '0;
      occ           <= '0;
      rx_byte_valid <= 1'b0;
      blk_good      <= 1'b0;
      blk_bad       <= 1'b0;
    end else begin
      occ           <= occ_nxt;
      rx_byte_valid <= 1'b0;
      blk_good      <= 1'b0;
      blk_bad       <= 1'b0;
      unique case (state)
        S_IDLE: if (resp_done) begin
          state <= S_GAP;
          cnt   <= '0;
        end
        S_GAP: begin
          if (cnt == LAST_GAP) state <= S_HUNT;
          cnt <= cnt + 1'b1;
        end
        S_HUNT: if (!dat_in) begin
          state <= S_DATA;
          cnt   <= '0;
          crc   <= '0;
        end
        S_DATA: begin
          shreg         <= {shreg[6:0], dat_in};
          crc           <= crc_step;
          rx_byte_valid <= (cnt[2:0] == 3'd7);
          if (cnt == LAST_DATA) begin
            state <= S_CRC;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_CRC: begin
          crc <= crc_step;
          if (cnt == LAST_CRC) state <= S_ENDB;
          cnt <= cnt + 1'b1;
        end
        S_ENDB: begin
          blk_good <= pass;
          blk_bad  <= !pass;
          tok      <= {1'b0, (pass ? 3'b010 : 3'b101), 1'b1};
          state    <= S_TURN;
          cnt      <= '0;
        end
        S_TURN: begin
          if (cnt == LAST_TURN) begin
            state <= S_TOK;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_TOK: begin
          if (cnt == LAST_TOK) begin
            state <= (occ_nxt == FULL) ? S_BUSY : S_IDLE;
          end else begin
            tok <= {tok[TOK_W-2:0], 1'b0};
            cnt <= cnt + 1'b1;
          end
        end
        S_BUSY: if (occ_nxt != FULL) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6
  tok_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_oe) |-> !dat_out);

  // R4
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_good && blk_bad));

  // R4
  good_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_good && !$past(buf_release)) |-> (occ == $past(occ) + 1'b1));

  // R5
  bad_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_bad && !$past(buf_release)) |-> (occ == $past(occ)));

  // R7
  busy_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BUSY) |-> (occ == FULL));

  // R7
  occ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL);

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(occ) == '0 && !blk_good) |-> (occ == '0));

  // R3
  byte_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte_valid |=> !rx_byte_valid);
endmodule

// File: tb/tb_blk_write_rx.sv
`timescale 1ns/1ps
module tb_blk_write_rx;
  localparam int BYTES = 512;
  localparam int GAP   = 2;

  logic clk = 1'b0, rst_n = 1'b0, resp_done = 1'b0, dat_in = 1'b1, buf_release = 1'b0;
  logic dat_oe, dat_out, rx_byte_valid, blk_good, blk_bad;
  logic [7:0] rx_byte;

  always #2 clk = ~clk;

  blk_write_rx #(.BLOCK_BYTES(BYTES), .GAP_MIN(GAP), .TURN_CYC(2), .NUM_BUF(2)) dut (
    .clk(clk), .rst_n(rst_n), .resp_done(resp_done), .dat_in(dat_in),
    .buf_release(buf_release), .dat_oe(dat_oe), .dat_out(dat_out),
    .rx_byte(rx_byte), .rx_byte_valid(rx_byte_valid),
    .blk_good(blk_good), .blk_bad(blk_bad));

  int checks = 0, errors = 0;
  int byte_cnt = 0, byte_err = 0;
  logic [7:0] blk [BYTES];

  // seed, flip crc, bad end, extra gap, low in gap, resp mid, busy hold, exp good, exp busy
  localparam logic [25:0] VECS [6] = '{
    {8'h01, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 8'd0,  1'b1, 1'b0},
    {8'h5A, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0, 8'd10, 1'b1, 1'b1},
    {8'h33, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 8'd0,  1'b0, 1'b0},
    {8'hC3, 1'b0, 1'b1, 4'd3, 1'b0, 1'b0, 8'd0,  1'b0, 1'b0},
    {8'h00, 1'b0, 1'b0, 4'd5, 1'b1, 1'b0, 8'd3,  1'b1, 1'b1},
    {8'hFF, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 8'd0,  1'b1, 1'b1}
  };

  always @(negedge clk) begin
    if (rst_n && rx_byte_valid) begin
      if (byte_cnt >= BYTES || rx_byte !== blk[byte_cnt]) byte_err++;
      byte_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic put_bit(input logic b);
    dat_in = b;
    @(negedge clk);
  endtask

  task automatic pulse_release();
    buf_release = 1'b1;
    @(negedge clk);
    buf_release = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_block(input logic [7:0] seed, input bit flip, input bit badend,
                           input int xgap, input bit gaplow, input bit mid,
                           input bit exp_good, input bit exp_busy, input int hold,
                           input string tag);
    logic [15:0] crc;
    logic [4:0] obs, exp_tok;
    bit oe_ok, busy_ok;
    int bit_idx;
    crc = 16'h0;
    for (int i = 0; i < BYTES; i++) begin
      blk[i] = seed ^ 8'((i * 37) + (i >> 2));
      crc = crc ^ {blk[i], 8'h00};
      for (int j = 0; j < 8; j++) crc = crc[15] ? ((crc << 1) ^ 16'h1021) : (crc << 1);
    end
    if (flip) crc = crc ^ 16'h0100;
    byte_cnt = 0;
    byte_err = 0;
    @(negedge clk);
    resp_done = 1'b1;
    @(negedge clk);
    resp_done = 1'b0;
    for (int g = 0; g < GAP; g++) put_bit(gaplow ? 1'b0 : 1'b1);
    for (int g = 0; g < xgap; g++) put_bit(1'b1);
    put_bit(1'b0);
    bit_idx = 0;
    for (int i = 0; i < BYTES; i++) begin
      for (int j = 7; j >= 0; j--) begin
        resp_done = mid && (bit_idx == 80);
        put_bit(blk[i][j]);
        bit_idx++;
      end
    end
    resp_done = 1'b0;
    for (int j = 15; j >= 0; j--) put_bit(crc[j]);
    put_bit(badend ? 1'b0 : 1'b1);
    dat_in = 1'b1;
    // first negedge after end-bit edge k
    if (exp_good) chk(blk_good && !blk_bad, "R4", {tag, " good strobe"}, {blk_good, blk_bad}, 2'b10);
    else          chk(!blk_good && blk_bad, "R5", {tag, " bad strobe"}, {blk_good, blk_bad}, 2'b01);
    if (gaplow) chk(blk_good == exp_good, "R2", {tag, " low gap samples ignored"}, blk_good, exp_good);
    if (mid)    chk(blk_good == exp_good, "R9", {tag, " mid-block resp_done ignored"}, blk_good, exp_good);
    oe_ok = !dat_oe;
    @(negedge clk);
    oe_ok = oe_ok && !dat_oe;
    for (int t = 4; t >= 0; t--) begin
      @(negedge clk);
      oe_ok = oe_ok && dat_oe;
      obs[t] = dat_out;
    end
    exp_tok = exp_good ? 5'b00101 : 5'b01011;
    chk(oe_ok, "R6", {tag, " drive window"}, oe_ok, 1);
    chk(obs == exp_tok, exp_good ? "R4" : "R5", {tag, " status token"}, obs, exp_tok);
    @(negedge clk);
    if (exp_busy) begin
      busy_ok = dat_oe && !dat_out;
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        busy_ok = busy_ok && dat_oe && !dat_out;
      end
      chk(busy_ok, "R7", {tag, " busy held low"}, busy_ok, 1);
      buf_release = 1'b1;
      @(negedge clk);
      buf_release = 1'b0;
      chk(!dat_oe, "R8", {tag, " release ends busy"}, dat_oe, 0);
    end else begin
      chk(!dat_oe, "R7", {tag, " no busy with free buffer"}, dat_oe, 0);
    end
    chk(byte_cnt == BYTES && byte_err == 0, "R3", {tag, " payload bytes"}, byte_cnt * 65536 + byte_err, BYTES * 65536);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!dat_oe && !rx_byte_valid && !blk_good && !blk_bad, "R1", "reset outputs",
        {dat_oe, rx_byte_valid, blk_good, blk_bad}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      run_block(VECS[v][25:18], VECS[v][17], VECS[v][16], int'(VECS[v][15:12]),
                VECS[v][11], VECS[v][10], VECS[v][1], VECS[v][0], int'(VECS[v][9:2]),
                $sformatf("row%0d", v));
    end

    // one buffer held: free it, then a release on empty must be ignored
    pulse_release();
    pulse_release();
    run_block(8'h77, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R8 empty release a");
    run_block(8'h88, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b1, 1, "R8 empty release b");

    // reset in the middle of a block
    @(negedge clk);
    resp_done = 1'b1;
    @(negedge clk);
    resp_done = 1'b0;
    for (int g = 0; g < GAP; g++) put_bit(1'b1);
    put_bit(1'b0);
    for (int i = 0; i < 100; i++) put_bit(i[0]);
    rst_n = 1'b0;
    dat_in = 1'b1;
    @(negedge clk);
    chk(!dat_oe && !rx_byte_valid && !blk_good && !blk_bad, "R1", "reset mid-block",
        {dat_oe, rx_byte_valid, blk_good, blk_bad}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_block(8'h12, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R1 after reset a");
    run_block(8'h34, 1'b0, 1'b0, 2, 1'b0, 1'b0, 1'b1, 1'b1, 2, "R1 after reset b");

    summary();
  end
endmodule